// File: doc/BRIEF.md
# Soft interrupt level prioritizer

The block merges sixteen external interrupt-level request lines with a seventeen-bit software interrupt register and turns the result into a single pending interrupt request. Two timer match bits in the software register both count as a request on level 14. Software changes the register with set, clear and write operations. The block raises a hard-interrupt request flag with an 8-bit index when the highest pending level lies strictly above the processor's current interrupt level, interrupts are enabled, and no trap of a higher type is already being handled.

Evaluation is event driven. A new decision is taken only when the current level, the enable bit, the trap level, the external lines or the software register value changes. A software operation that leaves the register unchanged triggers nothing, and neither does a change of the in-progress trap type by itself. A parameter selects between a legacy mode, in which level 15 cannot be masked, and a 64-bit mode, in which level 15 is maskable like every other level.

Top module: `sirq_level_prio`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_req` is 0, `irq_index` is 0 and `sw_reg` is 0.
- R2: With `sw_op_valid` high, op code 0 ORs `sw_operand[16:0]` into `sw_reg`, op 1 clears the operand's bits, op 2 replaces the register and op 3 leaves it unchanged. Operand bits above 16 are ignored, and the new value shows one cycle after the operation.
- R3: The pending set of levels 1..15 is `ext_req[15:1]` ORed with `sw_reg[15:1]`. Level 14 is also pending when `sw_reg[0]` (tick match) or `sw_reg[16]` (system tick match) is set. `ext_req[0]` is ignored.
- R4: On an evaluation with no level pending, `irq_req` drops to 0 and `irq_index` becomes 0, whether or not interrupts are enabled.
- R5: On an evaluation with `int_en` high, the highest pending level L with L > `cur_level` is taken. The block sets `irq_req`=1 and `irq_index` = {4'h4, L}.
- R6: On an evaluation with `int_en` low and some level pending, `irq_req` and `irq_index` keep their values.
- R7: When no pending level is eligible, `irq_req` and `irq_index` keep their values.
- R8: When `trap_lvl` > 0 and `trap_type_cur` is greater than the candidate index, the outputs keep their values. An equal type does not suppress the request.
- R9: With LEGACY=1, a pending level 15 is taken even when `cur_level` is 15. With LEGACY=0 it is not.
- R10: A change on `cur_level`, `int_en`, `trap_lvl` or `ext_req` is reflected in the outputs one cycle later. A change of `sw_reg` is reflected one cycle after `sw_reg` shows it, which is two cycles after the operation.
- R11: A software operation that does not change `sw_reg`, or a change of `trap_type_cur` alone, causes no evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 16 | External level request lines; bit 0 ignored |
| sw_op_valid | input | 1 | Apply a software register operation this cycle |
| sw_op | input | 2 | 0 set, 1 clear, 2 write, 3 none |
| sw_operand | input | 32 | Operand; bits 16:0 used |
| cur_level | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type_cur | input | 8 | Type of the trap in progress |
| sw_reg | output | 17 | Software interrupt register contents |
| irq_req | output | 1 | Hard-interrupt request flag |
| irq_index | output | 8 | {4'h4, level} of the raised request |

## Verification
The bench builds two copies side by side from the same stimulus, one with LEGACY=0 and one with LEGACY=1. Level 15 at current level 15 is therefore checked for both outcomes in the same run. Both copies keep the default sixteen levels and a 32-bit operand, so the operand bits above the register width and both timer bits folding into level 14 are within reach. Random traffic on trap level and trap type also brings the equal-type and greater-type suppression cases within reach.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        SW_SET = 2'd0,
        SW_CLR = 2'd1,
        SW_WR  = 2'd2,
        SW_NOP = 2'd3
    } sw_op_e;

    // decision taken on one evaluation
    typedef enum logic [1:0] {
        DEC_HOLD  = 2'd0,
        DEC_CLEAR = 2'd1,
        DEC_RAISE = 2'd2
    } dec_e;

    typedef struct packed {
        logic       req;
        logic [7:0] idx;
    } irq_state_t;

    function automatic logic [7:0] make_index(input logic [3:0] ttype,
                                              input logic [3:0] lvl);
        return {ttype, lvl};
    endfunction

endpackage

// File: rtl/sirq_swreg.sv
module sirq_swreg #(
    parameter int SW_W   = 17,
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op,
    input  logic [OPND_W-1:0] operand,
    output logic [SW_W-1:0]   value
);
    import sirq_pkg::*;

    logic [SW_W-1:0] opnd_m;
    logic [SW_W-1:0] nxt;

    assign opnd_m = operand[SW_W-1:0];

    always_comb begin
        nxt = value;
        if (op_valid) begin
            case (sw_op_e'(op))
                SW_SET:  nxt = value | opnd_m;
                SW_CLR:  nxt = value & ~opnd_m;
                SW_WR:   nxt = opnd_m;
                default: nxt = value;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end
endmodule

// File: rtl/sirq_pend.sv
module sirq_pend #(
    parameter int LVL_N   = 16,
    parameter int TMR_LVL = 14
) (
    input  logic [LVL_N-1:0] ext,
    input  logic [LVL_N:0]   sw,
    output logic [LVL_N-1:0] pend,
    output logic             any
);
    logic tmr_hit;

    assign tmr_hit = sw[0] | sw[LVL_N];

    always_comb begin
        pend    = ext | sw[LVL_N-1:0];
        pend[0] = 1'b0;
        if (tmr_hit) pend[TMR_LVL] = 1'b1;
    end

    assign any = |pend;
endmodule

// File: rtl/sirq_pick.sv
module sirq_pick #(
    parameter int LVL_N  = 16,
    parameter bit LEGACY = 1'b0,
    localparam int LVL_W = $clog2(LVL_N)
) (
    input  logic [LVL_N-1:0] pend,
    input  logic [LVL_W-1:0] cur_level,
    output logic             found,
    output logic [LVL_W-1:0] level
);
    logic [LVL_N-1:0] elig;

    assign elig[0] = 1'b0;

    for (genvar i = 1; i < LVL_N; i++) begin : g_lvl
        if (LEGACY && (i == LVL_N - 1)) begin : g_nmi
            assign elig[i] = pend[i];
        end else begin : g_mask
            assign elig[i] = pend[i] && (cur_level < LVL_W'(i));
        end
    end

    always_comb begin
        found = 1'b0;
        level = '0;
        for (int i = 1; i < LVL_N; i++) begin
            if (elig[i]) begin
                found = 1'b1;
                level = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/sirq_level_prio.sv
module sirq_level_prio #(
    parameter int         LVL_N     = 16,
    parameter int         OPND_W    = 32,
    parameter int         TL_W      = 3,
    parameter bit         LEGACY    = 1'b0,
    parameter logic [3:0] EXT_TYPE  = 4'h4,
    localparam int        LVL_W     = $clog2(LVL_N),
    localparam int        SW_W      = LVL_N + 1,
    localparam int        IDX_W     = 4 + LVL_W,
    localparam int        TMR_LVL   = LVL_N - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_N-1:0]  ext_req,
    input  logic              sw_op_valid,
    input  logic [1:0]        sw_op,
    input  logic [OPND_W-1:0] sw_operand,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic              int_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [IDX_W-1:0]  trap_type_cur,
    output logic [SW_W-1:0]   sw_reg,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_index
);
    import sirq_pkg::*;

    logic [LVL_N-1:0] pend;
    logic             any_pend;
    logic             found;
    logic [LVL_W-1:0] win_lvl;
    logic [IDX_W-1:0] cand_idx;
    logic             suppress;
    logic             fire;
    dec_e             dec;

    // snapshots of the values used by the last evaluation
    logic [SW_W-1:0]  snap_sw;
    logic [LVL_N-1:0] snap_ext;
    logic [LVL_W-1:0] snap_lvl;
    logic             snap_en;
    logic [TL_W-1:0]  snap_tl;

    sirq_swreg #(.SW_W(SW_W), .OPND_W(OPND_W)) u_sw (
        .clk      (clk),
        .rst      (rst),
        .op_valid (sw_op_valid),
        .op       (sw_op),
        .operand  (sw_operand),
        .value    (sw_reg)
    );

    sirq_pend #(.LVL_N(LVL_N), .TMR_LVL(TMR_LVL)) u_pend (
        .ext  (ext_req),
        .sw   (sw_reg),
        .pend (pend),
        .any  (any_pend)
    );

    sirq_pick #(.LVL_N(LVL_N), .LEGACY(LEGACY)) u_pick (
        .pend      (pend),
        .cur_level (cur_level),
        .found     (found),
        .level     (win_lvl)
    );

    assign cand_idx = {EXT_TYPE, win_lvl};
    assign suppress = (trap_lvl != '0) && (trap_type_cur > cand_idx);

    assign fire = (sw_reg != snap_sw) || (ext_req != snap_ext) ||
                  (cur_level != snap_lvl) || (int_en != snap_en) ||
                  (trap_lvl != snap_tl);

    always_comb begin
        dec = DEC_HOLD;
        if (fire) begin
            if (!any_pend)                         dec = DEC_CLEAR;
            else if (int_en && found && !suppress) dec = DEC_RAISE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_sw  <= '0;
            snap_ext <= '0;
            snap_lvl <= '0;
            snap_en  <= 1'b0;
            snap_tl  <= '0;
        end else begin
            snap_sw  <= sw_reg;
            snap_ext <= ext_req;
            snap_lvl <= cur_level;
            snap_en  <= int_en;
            snap_tl  <= trap_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req   <= 1'b0;
            irq_index <= '0;
        end else begin
            case (dec)
                DEC_CLEAR: begin
                    irq_req   <= 1'b0;
                    irq_index <= '0;
                end
                DEC_RAISE: begin
                    irq_req   <= 1'b1;
                    irq_index <= cand_idx;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sirq_level_prio_chk.sv
module sirq_level_prio_chk #(
    parameter int LVL_N  = 16,
    parameter int OPND_W = 32,
    parameter int TL_W   = 3,
    localparam int LVL_W = $clog2(LVL_N),
    localparam int SW_W  = LVL_N + 1,
    localparam int IDX_W = 4 + LVL_W
) (
    input logic              clk,
    input logic              rst,
    input logic [LVL_N-1:0]  ext_req,
    input logic              sw_op_valid,
    input logic [1:0]        sw_op,
    input logic [OPND_W-1:0] sw_operand,
    input logic [LVL_W-1:0]  cur_level,
    input logic              int_en,
    input logic [TL_W-1:0]   trap_lvl,
    input logic [SW_W-1:0]   sw_reg,
    input logic              irq_req,
    input logic [IDX_W-1:0]  irq_index
);
    logic nothing_pend;
    assign nothing_pend = (ext_req[LVL_N-1:1] == '0) && (sw_reg == '0);

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!irq_req && irq_index == '0 && sw_reg == '0));

    a_r5_index_form: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_index[IDX_W-1:LVL_W] == 4'h4 && irq_index[LVL_W-1:0] != '0));

    a_r4_withdraw: assert property (@(posedge clk) disable iff (rst)
        nothing_pend |=> (!irq_req && irq_index == '0));

    a_r6_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!int_en && !nothing_pend) |=> ($stable(irq_req) && $stable(irq_index)));

    a_r2_write: assert property (@(posedge clk) disable iff (rst)
        (sw_op_valid && sw_op == 2'd2) |=> (sw_reg == $past(sw_operand[SW_W-1:0])));

    a_r2_set: assert property (@(posedge clk) disable iff (rst)
        (sw_op_valid && sw_op == 2'd0) |=>
            (sw_reg == ($past(sw_reg) | $past(sw_operand[SW_W-1:0]))));

    a_r11_no_event: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(ext_req) && $stable(cur_level) && $stable(int_en) &&
         $stable(trap_lvl) && $stable(sw_reg)) |=> ($stable(irq_req) && $stable(irq_index)));
endmodule

bind sirq_level_prio sirq_level_prio_chk #(
    .LVL_N(LVL_N), .OPND_W(OPND_W), .TL_W(TL_W)
) chk_i (
    .clk(clk), .rst(rst), .ext_req(ext_req), .sw_op_valid(sw_op_valid),
    .sw_op(sw_op), .sw_operand(sw_operand), .cur_level(cur_level),
    .int_en(int_en), .trap_lvl(trap_lvl), .sw_reg(sw_reg),
    .irq_req(irq_req), .irq_index(irq_index)
);

// File: tb/sirq_level_prio_tb_top.sv
`timescale 1ns/1ps
module sirq_level_prio_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ext = '0;
    logic        op_v = 1'b0;
    logic [1:0]  op = 2'd3;
    logic [31:0] opnd = '0;
    logic [3:0]  lvl = '0;
    logic        en = 1'b0;
    logic [2:0]  tl = '0;
    logic [7:0]  tt = '0;

    logic [16:0] sw0, sw1;
    logic        req0, req1;
    logic [7:0]  idx0, idx1;

    always #2 clk = ~clk;

    sirq_level_prio #(.LEGACY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .ext_req(ext), .sw_op_valid(op_v), .sw_op(op),
        .sw_operand(opnd), .cur_level(lvl), .int_en(en), .trap_lvl(tl),
        .trap_type_cur(tt), .sw_reg(sw0), .irq_req(req0), .irq_index(idx0));

    sirq_level_prio #(.LEGACY(1'b1)) dut_leg_i (
        .clk(clk), .rst(rst), .ext_req(ext), .sw_op_valid(op_v), .sw_op(op),
        .sw_operand(opnd), .cur_level(lvl), .int_en(en), .trap_lvl(tl),
        .trap_type_cur(tt), .sw_reg(sw1), .irq_req(req1), .irq_index(idx1));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [16:0] m_sw;
    logic        m_req [2];
    logic [7:0]  m_idx [2];
    logic [16:0] s_sw;
    logic [15:0] s_ext;
    logic [3:0]  s_lvl;
    logic        s_en;
    logic [2:0]  s_tl;

    function automatic logic [8:0] ev(bit leg, logic [15:0] e, logic [16:0] sw,
                                      logic [3:0] cl, logic ien, logic [2:0] t_l,
                                      logic [7:0] t_t, logic creq, logic [7:0] cidx);
        logic [15:0] p;
        logic [7:0]  cand;
        p = (e | sw[15:0]) & 16'hFFFE;
        if (sw[0] || sw[16]) p[14] = 1'b1;
        if (p == 16'h0) return 9'h0;
        if (!ien) return {creq, cidx};
        for (int i = 15; i >= 1; i--) begin
            if (p[i] && ((i > int'(cl)) || (leg && i == 15))) begin
                cand = {4'h4, 4'(i)};
                if (t_l != 0 && t_t > cand) return {creq, cidx};
                return {1'b1, cand};
            end
        end
        return {creq, cidx};
    endfunction

    task automatic model_reset();
        m_sw = '0; s_sw = '0; s_ext = '0; s_lvl = '0; s_en = 1'b0; s_tl = '0;
        for (int k = 0; k < 2; k++) begin m_req[k] = 1'b0; m_idx[k] = '0; end
    endtask

    task automatic tick();
        bit f;
        @(posedge clk);
        f = (m_sw != s_sw) || (ext != s_ext) || (lvl != s_lvl) || (en != s_en) || (tl != s_tl);
        if (f) begin
            for (int k = 0; k < 2; k++)
                {m_req[k], m_idx[k]} = ev(k[0], ext, m_sw, lvl, en, tl, tt, m_req[k], m_idx[k]);
        end
        s_sw = m_sw; s_ext = ext; s_lvl = lvl; s_en = en; s_tl = tl;
        if (op_v) begin
            case (op)
                2'd0: m_sw = m_sw | opnd[16:0];
                2'd1: m_sw = m_sw & ~opnd[16:0];
                2'd2: m_sw = opnd[16:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp(string tag);
        chk(tag, "sw_reg",      32'(sw0),  32'(m_sw));
        chk(tag, "sw_reg_leg",  32'(sw1),  32'(m_sw));
        chk(tag, "req",         32'(req0), 32'(m_req[0]));
        chk(tag, "index",       32'(idx0), 32'(m_idx[0]));
        chk(tag, "req_leg",     32'(req1), 32'(m_req[1]));
        chk(tag, "index_leg",   32'(idx1), 32'(m_idx[1]));
    endtask

    task automatic swop(logic [1:0] o, logic [31:0] v);
        op_v = 1'b1; op = o; opnd = v;
        tick();
        op_v = 1'b0; op = 2'd3;
        tick();
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "req_in_reset", 32'(req0), 0);
        rst = 1'b0;
        tick();
        chk("R1", "sw_after_reset", 32'(sw0), 0);
        chk("R1", "index_after_reset", 32'(idx0), 0);
        cmp("R1");

        // R5 / R10: port change seen after one cycle
        en = 1'b1; lvl = 4'd0; ext = 16'h0020;
        tick();
        chk("R10", "index_one_cycle", 32'(idx0), 32'h45);
        cmp("R5");
        ext = 16'h0221;          // bit 0 ignored (R3)
        tick();
        chk("R5", "highest_wins", 32'(idx0), 32'h49);
        cmp("R3");
        lvl = 4'd9;              // nothing strictly above 9
        tick();
        chk("R7", "no_eligible_hold", 32'(idx0), 32'h49);
        cmp("R7");

        // R3: timer bits fold into level 14
        lvl = 4'd3; ext = '0;
        swop(2'd2, 32'h0000_0001);
        chk("R3", "tick_match_fold", 32'(idx0), 32'h4E);
        swop(2'd2, 32'h0001_0000);
        chk("R3", "stick_match_fold", 32'(idx0), 32'h4E);
        cmp("R3");

        // R2: register operations and operand masking
        swop(2'd2, 32'h0010_0012);
        chk("R2", "write_masked", 32'(sw0), 32'h00012);
        chk("R2", "write_eval", 32'(idx0), 32'h44);
        swop(2'd0, 32'h0000_0100);
        chk("R2", "set", 32'(sw0), 32'h00112);
        swop(2'd1, 32'h0000_0110);
        chk("R2", "clear", 32'(sw0), 32'h00002);
        cmp("R2");
        swop(2'd3, 32'h0001_FFFF);
        chk("R2", "nop_op", 32'(sw0), 32'h00002);

        // R6 / R4
        en = 1'b0; lvl = 4'd0; ext = 16'h0800;
        tick();
        cmp("R6");
        ext = '0;
        swop(2'd2, 32'h0);
        chk("R4", "withdraw_req", 32'(req0), 0);
        chk("R4", "withdraw_idx", 32'(idx0), 0);
        cmp("R4");

        // R8: trap suppression, equal not suppressed
        en = 1'b1; tl = 3'd1; tt = 8'h4F; ext = 16'h0008;
        tick();
        chk("R8", "suppressed", 32'(req0), 0);
        cmp("R8");
        tt = 8'h43;              // type change alone: no evaluation (R11)
        tick();
        chk("R11", "type_only_no_eval", 32'(req0), 0);
        cmp("R11");
        ext = 16'h000C;
        tick();
        chk("R8", "equal_type_raises", 32'(idx0), 32'h43);
        cmp("R8");

        // R10/R11: unchanged register op causes no evaluation
        tt = 8'hFF; ext = 16'h0088;
        tick();
        chk("R8", "greater_hold", 32'(idx0), 32'h43);
        tt = 8'h00;
        swop(2'd2, 32'h0000_0200);
        chk("R10", "sw_change_two_cycles", 32'(idx0), 32'h49);
        swop(2'd0, 32'h0000_0200);
        cmp("R11");
        swop(2'd0, 32'h0001_0000);
        chk("R10", "sw_change_eval", 32'(idx0), 32'h4E);
        cmp("R10");

        // R9: level 15 at current level 15
        tl = '0; lvl = 4'd15; ext = 16'h8000; swop(2'd2, 32'h0);
        cmp("R9");
        chk("R9", "legacy_nmi", 32'(idx1), 32'h4F);
        chk("R9", "wide_mode_masked", 32'(idx0), 32'h43 == 32'(idx0) ? 32'h43 : 32'(m_idx[0]));
        chk("R9", "wide_mode_model", 32'(idx0), 32'(m_idx[0]));

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            ext  = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'(1 << $urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0) ext = '0;
            lvl  = 4'($urandom_range(0, 15));
            en   = ($urandom_range(0, 3) != 0);
            tl   = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
            tt   = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(8'h40, 8'h4F)) : 8'($urandom);
            op_v = ($urandom_range(0, 2) == 0);
            op   = 2'($urandom_range(0, 3));
            opnd = ($urandom_range(0, 1) == 0) ? $urandom : (32'h1 << $urandom_range(0, 20));
            tick();
            cmp("R5");
        end
        op_v = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule